// File: doc/BRIEF.md
# Integer ALU with Condition Codes

This block is the arithmetic and logic unit of a small 32-bit RISC core. It combines a first operand with a second one that comes either from a register value or from a 13-bit signed immediate, which is widened to 32 bits. It computes bitwise AND, OR and NOR, a two's complement add, logical and arithmetic right shifts, and a set-high result that places a 22-bit constant at the top of the word. The result is combinational and is ready in the same cycle as the operands.

Four condition flags are held in registers: negative, zero, overflow and carry. They are loaded on a clock edge only when the operation is one of the flag-setting variants (the logic ops and add), the instruction asks for a flag update, and an enable input is high. In every other case the flags keep their value. Reset is asynchronous and active low. Its release passes through a two-stage synchronizer inside the block.

Top module: `cc_alu`

## Requirements
- R1: When `imm_sel` is 1, the second operand is `imm13` with bit 12 copied into bits 31 to 13. When it is 0, the second operand is `b_reg`.
- R2: Opcode 0 gives AND, 1 gives OR and 2 gives NOR, each bitwise. NOR with a zero second operand gives the complement of `a_in`.
- R3: Opcode 3 gives the 32-bit two's complement sum of the two operands in the same cycle.
- R4: Opcode 4 shifts `a_in` right by bits 4:0 of the second operand and fills the vacated bits with zeros. The upper bits of the second operand have no effect.
- R5: Opcode 5 shifts `a_in` right by bits 4:0 of the second operand and fills the vacated bits with copies of `a_in[31]`.
- R6: Opcode 6 gives `hi_const` in bits 31:10 and zeros in bits 9:0. Both operands are ignored.
- R7: Opcode 7 is reserved. It gives a zero result and never changes the flags.
- R8: On a flag update, at the next rising clock edge `flag_n` takes result bit 31 and `flag_z` is set exactly when the result is zero.
- R9: A flag update for opcodes 0 to 2 clears `flag_v` and `flag_c`.
- R10: A flag update for opcode 3 loads `flag_c` with the carry out of bit 31. It loads `flag_v` with 1 exactly when both operands have the same sign and the sum has the other sign.
- R11: The flags update only when `set_cc` and `cc_en` are both 1 and the opcode is 0 to 3. Otherwise all four flags keep their value.
- R12: While reset is active, and right after it, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 3 | Operation code, 0 to 7 |
| set_cc | input | 1 | The instruction is a flag-setting variant |
| cc_en | input | 1 | Enables the flag update |
| a_in | input | 32 | First operand |
| b_reg | input | 32 | Second operand taken from a register |
| imm_sel | input | 1 | Selects the immediate as the second operand |
| imm13 | input | 13 | Signed immediate |
| hi_const | input | 22 | Constant for the set-high operation |
| result | output | 32 | Combinational result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
`result` depends only on the inputs, so it is due in the same cycle. The bench drives inputs on a falling edge and compares `result` 1 ns later, well before the next rising edge. The flags pass through a single register, so they are due at the first rising edge after the request. The bench samples them 1 ns after that edge and compares them with a flag model that updates only under the R11 condition. The synchronizer delays the end of reset by two edges, so no stimulus is applied until three cycles after `rst_n` rises.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

  typedef enum logic [2:0] {
    OP_AND   = 3'd0,
    OP_OR    = 3'd1,
    OP_NOR   = 3'd2,
    OP_ADD   = 3'd3,
    OP_SRL   = 3'd4,
    OP_SRA   = 3'd5,
    OP_SETHI = 3'd6,
    OP_RSVD  = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

endpackage

// File: rtl/cc_alu_opnd.sv
// Second-operand select: register value or widened signed immediate.
module cc_alu_opnd #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 13
) (
  input  logic [DATA_W-1:0] reg_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  output logic [DATA_W-1:0] opnd
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] widened;

  assign widened = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign opnd    = use_imm ? widened : reg_val;
endmodule

// File: rtl/cc_alu_add.sv
// Two's complement adder with carry out and signed overflow.
module cc_alu_add #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide;

  assign wide  = {1'b0, x} + {1'b0, y};
  assign sum   = wide[MSB:0];
  assign carry = wide[DATA_W];
  assign ovf   = (x[MSB] == y[MSB]) & (sum[MSB] ^ x[MSB]);
endmodule

// File: rtl/cc_alu_shift.sv
// Logarithmic right shifter; fill is zero or the sign bit.
module cc_alu_shift #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  input  logic              arith,
  output logic [DATA_W-1:0] dout
);
  logic              fill;
  logic [DATA_W-1:0] stage [SH_W+1];

  assign fill     = arith & din[DATA_W-1];
  assign stage[0] = din;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int DIST = 1 << s;
    assign stage[s+1] = amt[s] ? {{DIST{fill}}, stage[s][DATA_W-1:DIST]}
                               : stage[s];
  end

  assign dout = stage[SH_W];
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 13,
  parameter int HI_W   = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_sel,
  input  logic              set_cc,
  input  logic              cc_en,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_reg,
  input  logic              imm_sel,
  input  logic [IMM_W-1:0]  imm13,
  input  logic [HI_W-1:0]   hi_const,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);
  localparam int SH_W = $clog2(DATA_W);
  localparam int LO_W = DATA_W - HI_W;
  localparam int MSB  = DATA_W - 1;

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] add_sum;
  logic              add_c;
  logic              add_v;
  logic [DATA_W-1:0] shr_out;

  cc_alu_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .reg_val (b_reg),
    .imm     (imm13),
    .use_imm (imm_sel),
    .opnd    (opb)
  );

  cc_alu_add #(.DATA_W(DATA_W)) u_add (
    .x     (a_in),
    .y     (opb),
    .sum   (add_sum),
    .carry (add_c),
    .ovf   (add_v)
  );

  cc_alu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .din   (a_in),
    .amt   (opb[SH_W-1:0]),
    .arith (op == OP_SRA),
    .dout  (shr_out)
  );

  // Result select.
  logic [DATA_W-1:0] res_c;

  always_comb begin
    unique case (op)
      OP_AND:   res_c = a_in & opb;
      OP_OR:    res_c = a_in | opb;
      OP_NOR:   res_c = ~(a_in | opb);
      OP_ADD:   res_c = add_sum;
      OP_SRL,
      OP_SRA:   res_c = shr_out;
      OP_SETHI: res_c = {hi_const, {LO_W{1'b0}}};
      default:  res_c = '0;
    endcase
  end

  assign result = res_c;

  // Flag next-state and register.
  logic cc_upd;
  cc_t  cc_q;
  cc_t  cc_nxt;

  assign cc_upd = set_cc & cc_en &
                  ((op == OP_AND) | (op == OP_OR) | (op == OP_NOR) | (op == OP_ADD));

  always_comb begin
    cc_nxt.n = res_c[MSB];
    cc_nxt.z = ~|res_c;
    cc_nxt.v = (op == OP_ADD) & add_v;
    cc_nxt.c = (op == OP_ADD) & add_c;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      cc_q <= '0;
    else if (cc_upd) cc_q <= cc_nxt;
  end

  assign flag_n = cc_q.n;
  assign flag_z = cc_q.z;
  assign flag_v = cc_q.v;
  assign flag_c = cc_q.c;
endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk #(
  parameter int DATA_W = 32,
  parameter int HI_W   = 22
) (
  input logic              clk,
  input logic              rst_q,
  input logic [2:0]        op_sel,
  input logic              set_cc,
  input logic              cc_en,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] opb,
  input logic [DATA_W-1:0] result,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v,
  input logic              flag_c
);
  localparam int LO_W = DATA_W - HI_W;
  localparam int MSB  = DATA_W - 1;

  logic            req;
  logic [DATA_W:0] wide_ref;

  assign req      = set_cc & cc_en & (op_sel < 3'd4);
  assign wide_ref = {1'b0, a_in} + {1'b0, opb};

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_q)
    !req |=> ($stable(flag_n) && $stable(flag_z) && $stable(flag_v) && $stable(flag_c)));

  assert_nz_R8: assert property (@(posedge clk) disable iff (!rst_q)
    req |=> (flag_n == $past(result[MSB])) && (flag_z == ($past(result) == '0)));

  assert_logic_clr_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (req && op_sel != 3'd3) |=> (!flag_v && !flag_c));

  assert_add_carry_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (req && op_sel == 3'd3) |=> (flag_c == $past(wide_ref[DATA_W])));

  assert_sethi_low_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (op_sel == 3'd6) |-> (result[LO_W-1:0] == '0));

  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (op_sel == 3'd7) |-> (result == '0));
endmodule

bind cc_alu cc_alu_chk #(.DATA_W(DATA_W), .HI_W(HI_W)) u_chk (.*);

// File: tb/sim_cc_alu.sv
module sim_cc_alu;
  logic        clk;
  logic        rst_n;
  logic [2:0]  op_sel;
  logic        set_cc;
  logic        cc_en;
  logic [31:0] a_in;
  logic [31:0] b_reg;
  logic        imm_sel;
  logic [12:0] imm13;
  logic [21:0] hi_const;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_v, flag_c;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  logic m_n = 1'b0, m_z = 1'b0, m_v = 1'b0, m_c = 1'b0;

  cc_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .set_cc(set_cc), .cc_en(cc_en),
    .a_in(a_in), .b_reg(b_reg), .imm_sel(imm_sel), .imm13(imm13),
    .hi_const(hi_const), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input int i);
    case (i)
      0:  return 32'h0000_0000;
      1:  return 32'h0000_0001;
      2:  return 32'h0000_0002;
      3:  return 32'h7FFF_FFFF;
      4:  return 32'h8000_0000;
      5:  return 32'hFFFF_FFFF;
      6:  return 32'hFFFF_FFFE;
      7:  return 32'h8000_0001;
      8:  return 32'h5555_5555;
      9:  return 32'hAAAA_AAAA;
      10: return 32'h1234_5678;
      default: return 32'hFEDC_BA98;
    endcase
  endfunction

  function automatic logic [31:0] sext(input logic [12:0] v);
    int s;
    s = int'(v);
    if (s >= 4096) s = s - 8192;
    return 32'(s);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_flags(input string tag);
    check({28'd0, flag_n, flag_z, flag_v, flag_c}, {28'd0, m_n, m_z, m_v, m_c}, tag);
  endtask

  // Drives one operation, checks the result in the same cycle and the flags after the next edge.
  task automatic step(input logic [2:0] op, input logic sc, input logic ce,
                      input logic [31:0] a, input logic [31:0] b, input logic isel,
                      input logic [12:0] imm, input logic [21:0] hc, input string tag);
    logic [31:0] bb, er;
    logic ev, ec;
    longint sa, sb, ss;
    logic [32:0] w;
    @(negedge clk);
    op_sel = op; set_cc = sc; cc_en = ce; a_in = a; b_reg = b;
    imm_sel = isel; imm13 = imm; hi_const = hc;
    bb = isel ? sext(imm) : b;
    ev = 1'b0; ec = 1'b0;
    case (op)
      3'd0: er = a & bb;
      3'd1: er = a | bb;
      3'd2: er = ~(a | bb);
      3'd3: begin
        w  = {1'b0, a} + {1'b0, bb};
        er = w[31:0];
        ec = w[32];
        sa = longint'($signed(a)); sb = longint'($signed(bb)); ss = sa + sb;
        ev = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      3'd4: er = a >> bb[4:0];
      3'd5: er = 32'($signed(a) >>> bb[4:0]);
      3'd6: er = {hc, 10'd0};
      default: er = 32'd0;
    endcase
    #1;
    check(result, er, tag);
    if (sc && ce && op <= 3'd3) begin
      m_n = er[31]; m_z = (er == 32'd0); m_v = ev; m_c = ec;
    end
    @(posedge clk); #1;
    check_flags({tag, " flags R8 R9 R10 R11"});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_sel = 3'd0; set_cc = 1'b0; cc_en = 1'b0; a_in = '0;
    b_reg = '0; imm_sel = 1'b0; imm13 = '0; hi_const = '0;
    repeat (3) @(negedge clk);
    #1 check_flags("R12 during reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 check_flags("R12 after reset");

    // R2 R3 R8 R9 R10 R11: logic ops and add over all operand pairs, enables varied
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          step(3'(op), ((i + j) % 4) != 1, ((i + j) % 4) != 2, pat(i), pat(j), 1'b0,
               13'd0, 22'd0, op == 3 ? "R3 add" : "R2 logic");

    // R2: NOR with zero gives the complement
    for (int i = 0; i < 12; i++)
      step(3'd2, 1'b1, 1'b1, pat(i), 32'd0, 1'b0, 13'd0, 22'd0, "R2 nor-zero");

    // R4 R5 R11: every shift amount, junk in the upper operand bits, flag request ignored
    for (int sh = 0; sh < 2; sh++)
      for (int i = 0; i < 12; i++)
        for (int k = 0; k < 32; k++)
          step(sh == 0 ? 3'd4 : 3'd5, 1'b1, 1'b1, pat(i), {27'h5A5A5A5, 5'(k)},
               1'b0, 13'd0, 22'd0, sh == 0 ? "R4 srl" : "R5 sra");

    // R1: every immediate through OR with zero
    for (int v = 0; v < 8192; v++)
      step(3'd1, 1'b0, 1'b0, 32'd0, 32'hDEAD_BEEF, 1'b1, 13'(v), 22'd0, "R1 sext");

    // R1 R10: add with immediates at the edges
    for (int i = 0; i < 12; i++) begin
      step(3'd3, 1'b1, 1'b1, pat(i), 32'd0, 1'b1, 13'h1000, 22'd0, "R1 R10 add imm min");
      step(3'd3, 1'b1, 1'b1, pat(i), 32'd0, 1'b1, 13'h0FFF, 22'd0, "R1 R10 add imm max");
      step(3'd3, 1'b1, 1'b1, pat(i), 32'd0, 1'b1, 13'h1FFF, 22'd0, "R1 R10 add imm -1");
    end

    // R6 R11: set-high over spread constants, operands and flag request ignored
    for (int i = 0; i < 64; i++)
      step(3'd6, 1'b1, 1'b1, pat(i % 12), pat((i + 5) % 12), i[0], 13'h1ABC,
           22'((i * 65599) ^ (i << 16)), "R6 sethi");

    // R7: reserved opcode after a flag-setting op that leaves the flags nonzero
    step(3'd3, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 13'd0, 22'd0, "R10 setup");
    for (int i = 0; i < 12; i++)
      step(3'd7, 1'b1, 1'b1, pat(i), pat(11 - i), 1'b0, 13'd0, 22'h3FFFFF, "R7 reserved");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule